// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends a short command frame from a reader to a tag by switching the enable of an RF carrier. Between frames the carrier stays on. Each bit begins with a fixed carrier-off gap. The carrier then comes back on for a time that sets the bit's total length, and that length is the bit's value: a long period is a one and a short period is a zero. The frame has no start or stop symbol. A single extra carrier-off gap after the last bit marks its end.

All timing is counted in ticks. A one-cycle enable from an external prescaler supplies these ticks; by default the prescaler divides the system clock by 32. The gap length and both bit periods are parameters, with defaults of 30, 150 and 90 ticks. A frame starts with a one-cycle start strobe. The strobe loads a data word of up to 16 bits and a bit count. When the closing gap ends, the block emits a one-cycle done strobe. Surrounding logic uses this strobe to restart the timer that measures the tag's reply window from the end of the frame.

Top module: `pause_frame_tx`

## Requirements
- R1: After reset, and between frames, `carrier_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: Every data bit begins with `carrier_o` at 0 for exactly `PAUSE_TICKS` ticks.
- R3: A 1 bit lasts `ONE_TICKS` ticks in total and a 0 bit lasts `ZERO_TICKS` ticks, so the carrier-on part is `ONE_TICKS-PAUSE_TICKS` or `ZERO_TICKS-PAUSE_TICKS` ticks.
- R4: A start strobe accepted while idle latches `data_i` and `nbits_i`. In the next cycle `busy_o` is 1 and `carrier_o` is 0. Bits go out least significant first, `data_i[0]` through `data_i[nbits-1]`, and `busy_o` stays 1 until the frame ends.
- R5: After the last data bit there is one more carrier-off gap of `PAUSE_TICKS` ticks, and then the carrier returns to 1.
- R6: `done_o` is high for exactly one cycle. That cycle is the first one with the carrier back on after the closing gap, and `busy_o` is already 0 in it.
- R7: A start strobe while `busy_o` is 1 is ignored. The frame in progress keeps its data, its bit count and its timing.
- R8: A bit count of 0 produces only the closing gap of `PAUSE_TICKS` ticks, followed by `done_o`.
- R9: A bit count above 16 is treated as 16.
- R10: A tick is counted only in a cycle where `tick_en` is 1. In a cycle without a tick, `carrier_o` and the frame position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timing tick from the prescaler |
| start_i | input | 1 | Start strobe for a frame |
| data_i | input | 16 | Frame bits, sent LSB first |
| nbits_i | input | 5 | Number of bits to send (0 to 16, larger values clamp to 16) |
| carrier_o | output | 1 | RF carrier enable (1 = carrier on) |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle strobe at frame end, used to restart the reply timer |

## Verification
The assertions assume that `tick_en` is a single-cycle pulse and that `start_i` and `tick_en` are stable through each clock edge. They also assume parameters that satisfy `ZERO_TICKS > PAUSE_TICKS >= 2`. The bench builds the block with small tick counts and drives `tick_en` from a pseudo-random sequence that has gaps. Every carrier-off and carrier-on run is measured in ticks rather than in cycles and compared with lengths computed from the data word. The sweeps cover every bit count from 0 to 20 and every 8-bit data value, plus a start strobe issued in the middle of a frame.

// File: rtl/pft_pkg.sv
// Package: shared types for the pause-width frame transmitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pft_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BIT   = 2'd1,
        ST_CLOSE = 2'd2
    } pft_state_e;
endpackage

// File: rtl/pft_tick_counter.sv
// Tick counter: counts prescaler ticks within the current gap or bit period.
// Assumes clr has priority over a tick arriving in the same cycle.
module pft_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Clear at each period boundary, otherwise advance once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick_en) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pft_shifter.sv
// Shifter: holds the frame word and the number of bits still to send.
// Assumes len_i is already clamped to DATA_W and that load and shift never coincide.
module pft_shifter #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              cur_bit,
    output logic              last_bit
);
    logic [DATA_W-1:0] sr;
    logic [LEN_W-1:0]  left;

    // Load on an accepted start; drop the LSB after each finished bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
        end else if (load) begin
            sr   <= data_i;
            left <= len_i;
        end else if (shift) begin
            sr   <= sr >> 1;
            left <= left - 1'b1;
        end
    end

    // Present the current bit and flag when it is the final one.
    always_comb begin
        cur_bit  = sr[0];
        last_bit = (left == LEN_W'(1));
    end
endmodule

// File: rtl/pft_sequencer.sv
// Sequencer: walks idle -> bits -> closing gap and drives the carrier enable.
// Assumes tick_en is a one-cycle pulse and ZERO_TICKS > PAUSE_TICKS >= 1.
module pft_sequencer
    import pft_pkg::*;
#(
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start_i,
    input  logic             len_zero,
    input  logic             cur_bit,
    input  logic             last_bit,
    input  logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             shift,
    output logic             clr,
    output logic             carrier_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] PAUSE_C = CNT_W'(PAUSE_TICKS);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(ONE_TICKS);
    localparam logic [CNT_W-1:0] ZERO_C  = CNT_W'(ZERO_TICKS);

    pft_state_e       state, state_nx;
    logic [CNT_W-1:0] limit;
    logic             accept, period_end;

    // Decode the current period length and the step events.
    always_comb begin
        limit      = (state == ST_BIT) ? (cur_bit ? ONE_C : ZERO_C) : PAUSE_C;
        accept     = start_i && (state == ST_IDLE);
        period_end = (state != ST_IDLE) && tick_en && (cnt == limit - 1'b1);
        load       = accept;
        shift      = (state == ST_BIT) && period_end;
        clr        = accept || period_end;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)     state_nx = len_zero ? ST_CLOSE : ST_BIT;
            ST_BIT:   if (period_end) state_nx = last_bit ? ST_CLOSE : ST_BIT;
            ST_CLOSE: if (period_end) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // State register and the end-of-frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_o <= 1'b0;
        end else begin
            state  <= state_nx;
            done_o <= (state == ST_CLOSE) && period_end;
        end
    end

    // Carrier is on when idle and in the on-part of a bit, off during gaps.
    always_comb begin
        busy_o = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:  carrier_o = 1'b1;
            ST_BIT:   carrier_o = (cnt >= PAUSE_C);
            default:  carrier_o = 1'b0;
        endcase
    end

    // R3: the tick count never reaches the end of the current period.
    a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt < limit));

    // R4: an accepted start opens the frame with the carrier off.
    a_r4_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !carrier_o));

    // R6: done comes after a gap, with the carrier back on and busy dropped.
    a_r6_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (carrier_o && !busy_o && $past(!carrier_o)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a start while busy with no tick cannot end or restart the frame.
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !tick_en) |=> (busy_o && $stable(carrier_o)));

    // R10: without a tick nothing moves while a frame is in progress.
    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_en) |=> $stable(carrier_o));

    generate
        if (PAUSE_TICKS >= 2) begin : g_gap_chk
            // R2: a falling carrier stays off for at least the next cycle.
            a_r2_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(carrier_o) |=> !carrier_o);
        end
    endgenerate
endmodule

// File: rtl/pause_frame_tx.sv
// Top: pause-width encoded frame transmitter for a reader-to-tag command.
// Assumes a prescaler tick on tick_en and ZERO_TICKS > PAUSE_TICKS.
module pause_frame_tx #(
    parameter int DATA_W      = 16,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int LEN_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  nbits_i,
    output logic              carrier_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MAX_T = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic [LEN_W-1:0] len_eff;
    logic [CNT_W-1:0] cnt;
    logic             load, shift, clr, cur_bit, last_bit;

    // Clamp the requested bit count to the word width.
    always_comb begin
        len_eff = (nbits_i > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : nbits_i;
    end

    pft_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (clr),
        .cnt     (cnt)
    );

    pft_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .data_i   (data_i),
        .len_i    (len_eff),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    pft_sequencer #(
        .PAUSE_TICKS (PAUSE_TICKS),
        .ONE_TICKS   (ONE_TICKS),
        .ZERO_TICKS  (ZERO_TICKS),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .start_i   (start_i),
        .len_zero  (len_eff == '0),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit),
        .cnt       (cnt),
        .load      (load),
        .shift     (shift),
        .clr       (clr),
        .carrier_o (carrier_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );
endmodule

// File: tb/pause_frame_tx_tb.sv
// Bench: sweeps bit counts and data words, measures each carrier run in ticks.
module pause_frame_tx_tb_top;
    localparam int TP = 3;
    localparam int T1 = 9;
    localparam int T0 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [4:0]  nbits_i = '0;
    logic        carrier_o, busy_o, done_o;
    logic [7:0]  lf = 8'hA5;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    // Pseudo-random tick with gaps, changed just after each rising edge.
    always @(posedge clk) begin
        lf      <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tick_en <= rst_n & (lf[1:0] != 2'b00);
    end

    pause_frame_tx #(
        .PAUSE_TICKS (TP),
        .ONE_TICKS   (T1),
        .ZERO_TICKS  (T0)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .start_i   (start_i),
        .data_i    (data_i),
        .nbits_i   (nbits_i),
        .carrier_o (carrier_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Send one frame and compare every carrier run length (in ticks).
    task automatic run_frame(input logic [15:0] d, input int n, input bit poke);
        int  runs[40];
        int  k = 0;
        int  cnt = 0;
        int  guard = 0;
        int  eff = (n > 16) ? 16 : n;
        bit  prev = 1'b1;
        bit  started = 1'b0;
        bit  fin = 1'b0;
        bit  busy_ok = 1'b1;
        bit  c;
        string tag = poke ? "R7" : "R3";
        @(negedge clk);
        start_i = 1'b1;
        data_i  = d;
        nbits_i = 5'(n);
        while (!fin && guard < 5000) begin
            @(negedge clk);
            guard++;
            start_i = 1'b0;
            data_i  = ~d;
            if (poke && guard == 4) begin
                start_i = 1'b1;
                nbits_i = 5'd1;
            end
            c = carrier_o;
            if (c != prev) begin
                if (started && k < 40) begin
                    runs[k] = cnt;
                    k++;
                end
                started = 1'b1;
                cnt = 0;
            end
            cnt += int'(tick_en);
            prev = c;
            if (done_o) begin
                fin = 1'b1;
                check(!busy_o && carrier_o, "R6 done with carrier on, idle", int'(busy_o), 0);
            end else if (!busy_o) begin
                busy_ok = 1'b0;
            end
        end
        check(fin, "R6 done strobe seen", int'(fin), 1);
        check(busy_ok, "R4 busy held through frame", int'(busy_ok), 1);
        check(k == 2 * eff + 1, (eff == 0) ? "R8 run count" : "R9 R5 run count", k, 2 * eff + 1);
        if (k == 2 * eff + 1) begin
            for (int i = 0; i < eff; i++) begin
                check(runs[2*i] == TP, "R2 R10 bit gap ticks", runs[2*i], TP);
                check(runs[2*i+1] == (d[i] ? T1 - TP : T0 - TP),
                      {tag, " R4 on-time ticks"}, runs[2*i+1], d[i] ? T1 - TP : T0 - TP);
            end
            check(runs[2*eff] == TP, "R5 closing gap ticks", runs[2*eff], TP);
        end
        @(negedge clk);
        check(!done_o && carrier_o && !busy_o, "R1 R6 idle after done",
              {29'd0, done_o, carrier_o, busy_o}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(carrier_o === 1'b1, "R1 reset carrier", int'(carrier_o), 1);
        check(busy_o === 1'b0, "R1 reset busy", int'(busy_o), 0);
        check(done_o === 1'b0, "R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(carrier_o && !busy_o && !done_o, "R1 idle before first start",
              int'(carrier_o), 1);
        for (int n = 0; n <= 20; n++) begin
            run_frame(16'hFFFF, n, 1'b0);
            run_frame(16'h0000, n, 1'b0);
            run_frame(16'hA5C3, n, 1'b0);
        end
        for (int d = 0; d < 256; d++) begin
            run_frame(16'(d), 8, 1'b0);
        end
        run_frame(16'h02B6, 10, 1'b1);
        run_frame(16'h8001, 16, 1'b1);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule